// File: doc/BRIEF.md
# Double-Buffered Frequency Control Register Bank

This block is the write-side control store of a numerically controlled oscillator. A host writes the block one byte at a time over an 8-bit write-only bus, using a 4-bit address, a write clock and a write enable. Each byte lands in a master bank that holds a 48-bit center-frequency word, a 48-bit offset-frequency word and two term-zeroing flags. The write clock is independent of the oscillator clock and can run as fast as half of it.

The oscillator never reads the master bank directly. It sees a slave copy that sits in the oscillator clock domain. An active-low update input, synchronized by two flops, copies every master register into its slave in the same oscillator cycle. A host can therefore change any number of bytes, including only the bytes that differ, and the oscillator sees the whole new word at once. If the update input is held low, the slave bank follows the master bank on every oscillator clock. The oscillator-domain reset is applied asynchronously and released through its own two-flop synchronizer.

Top module: `freq_ctl_regs`

## Requirements
- R1: While reset is low, all slave outputs are zero, and every master register is cleared. An update issued after reset, with no writes, leaves all outputs at zero.
- R2: A write with wr_en high is captured on the rising edge of wr_clk. Addresses 0 to 5 load bytes 0 to 5 of the center word, least significant byte at address 0 (bits 8k+7:8k at address k).
- R3: Addresses 6 to 11 load bytes 0 to 5 of the offset word. Address 6+k holds bits 8k+7:8k.
- R4: Address 12 loads the flags. Data bit 0 sets center_zero and data bit 1 sets serial_zero. Data bits 7:2 are not stored.
- R5: A wr_clk rising edge with wr_en low changes no master register.
- R6: Writes to addresses 13, 14 and 15 change no master register.
- R7: While update_n stays high, the slave outputs hold their values whatever is written to the master bank.
- R8: When update_n falls, all outputs take the master values together on the third dds_clk rising edge after the fall. They do not change on the first or second edge.
- R9: While update_n is held low, a write reaches the outputs within three dds_clk rising edges.
- R10: Master bytes that are not written keep their previous values, so a partial write followed by an update changes only the written bytes.
- R11: When update_n returns high, the outputs keep the last values they loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| dds_clk | input | 1 | Oscillator clock; clocks the slave bank |
| wr_clk | input | 1 | Write clock; bytes are captured on its rising edge |
| wr_en | input | 1 | Write enable, active high |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Write data byte |
| update_n | input | 1 | Active-low master-to-slave transfer request |
| center_freq | output | 48 | Slave center-frequency word |
| offset_freq | output | 48 | Slave offset-frequency word |
| center_zero | output | 1 | Slave flag that zeroes the center term |
| serial_zero | output | 1 | Slave flag that zeroes the serial tuning term |

## Verification
Directed patterns come first. A full sequential load of all thirteen registers with distinct byte values exposes any swapped byte lane or wrong bank. A partial four-byte load shows whether unwritten bytes keep their values. Writes with the enable low and writes to the unused addresses show whether either kind leaks into storage. Every update is sampled after the first, second and third oscillator edge, which pins the transfer latency exactly. A held-low update separates the tracking mode from the one-shot transfer. Seeded random bursts then mix enables, addresses and data, with and without an update. The first kind of burst shows whether the slave bank leaks changes while update is inactive. The second shows whether a scattered set of byte writes all arrives in the same cycle.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  // destination chosen by the address decoder
  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_CENTER = 2'd1,
    SEL_OFFSET = 2'd2,
    SEL_CTRL   = 2'd3
  } fcr_sel_e;

  // flag positions inside the control byte
  localparam int CTRL_CZ_BIT = 0;
  localparam int CTRL_SZ_BIT = 1;
  localparam int CTRL_W      = 2;
endpackage

// File: rtl/fcr_sync.sv
module fcr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d;
    end else begin : g_chain
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/fcr_addr_decode.sv
module fcr_addr_decode
  import fcr_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int FREQ_BYTES = 6,
  localparam int IDX_W     = (FREQ_BYTES > 1) ? $clog2(FREQ_BYTES) : 1
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output fcr_sel_e          sel,
  output logic [IDX_W-1:0]  byte_idx
);
  localparam logic [ADDR_W-1:0] A_OFF  = ADDR_W'(FREQ_BYTES);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(2 * FREQ_BYTES);

  always_comb begin
    sel      = SEL_NONE;
    byte_idx = '0;
    if (wr_en) begin
      if (wr_addr < A_OFF) begin
        sel      = SEL_CENTER;
        byte_idx = IDX_W'(wr_addr);
      end else if (wr_addr < A_CTRL) begin
        sel      = SEL_OFFSET;
        byte_idx = IDX_W'(wr_addr - A_OFF);
      end else if (wr_addr == A_CTRL) begin
        sel      = SEL_CTRL;
      end
    end
  end
endmodule

// File: rtl/fcr_master_bank.sv
module fcr_master_bank
  import fcr_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int FREQ_BYTES = 6,
  localparam int IDX_W     = (FREQ_BYTES > 1) ? $clog2(FREQ_BYTES) : 1,
  localparam int FREQ_W    = BYTE_W * FREQ_BYTES
) (
  input  logic              wr_clk,
  input  logic              rst_n,
  input  fcr_sel_e          sel,
  input  logic [IDX_W-1:0]  byte_idx,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [FREQ_W-1:0] master_center,
  output logic [FREQ_W-1:0] master_offset,
  output logic [CTRL_W-1:0] master_ctrl
);
  generate
    for (genvar b = 0; b < FREQ_BYTES; b++) begin : g_byte
      logic [BYTE_W-1:0] ctr_q;
      logic [BYTE_W-1:0] off_q;
      logic              ctr_we;
      logic              off_we;

      always_comb begin
        ctr_we = (sel == SEL_CENTER) && (byte_idx == IDX_W'(b));
        off_we = (sel == SEL_OFFSET) && (byte_idx == IDX_W'(b));
      end

      always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n)      ctr_q <= '0;
        else if (ctr_we) ctr_q <= wr_data;
      end

      always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n)      off_q <= '0;
        else if (off_we) off_q <= wr_data;
      end

      assign master_center[b*BYTE_W +: BYTE_W] = ctr_q;
      assign master_offset[b*BYTE_W +: BYTE_W] = off_q;
    end
  endgenerate

  logic ctrl_we;
  always_comb ctrl_we = (sel == SEL_CTRL);

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n)       master_ctrl <= '0;
    else if (ctrl_we) master_ctrl <= wr_data[CTRL_W-1:0];
  end
endmodule

// File: rtl/fcr_slave_bank.sv
module fcr_slave_bank
  import fcr_pkg::*;
#(
  parameter int FREQ_W = 48
) (
  input  logic              dds_clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [FREQ_W-1:0] master_center,
  input  logic [FREQ_W-1:0] master_offset,
  input  logic [CTRL_W-1:0] master_ctrl,
  output logic [FREQ_W-1:0] slave_center,
  output logic [FREQ_W-1:0] slave_offset,
  output logic [CTRL_W-1:0] slave_ctrl
);
  logic [FREQ_W-1:0] center_d;
  logic [FREQ_W-1:0] offset_d;
  logic [CTRL_W-1:0] ctrl_d;

  always_comb begin
    center_d = slave_center;
    offset_d = slave_offset;
    ctrl_d   = slave_ctrl;
    if (load) begin
      center_d = master_center;
      offset_d = master_offset;
      ctrl_d   = master_ctrl;
    end
  end

  always_ff @(posedge dds_clk or negedge rst_n) begin
    if (!rst_n) begin
      slave_center <= '0;
      slave_offset <= '0;
      slave_ctrl   <= '0;
    end else begin
      slave_center <= center_d;
      slave_offset <= offset_d;
      slave_ctrl   <= ctrl_d;
    end
  end
endmodule

// File: rtl/freq_ctl_regs.sv
module freq_ctl_regs
  import fcr_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int FREQ_BYTES  = 6,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = (FREQ_BYTES > 1) ? $clog2(FREQ_BYTES) : 1,
  localparam int FREQ_W     = BYTE_W * FREQ_BYTES
) (
  input  logic              rst_n,
  input  logic              dds_clk,
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              update_n,
  output logic [FREQ_W-1:0] center_freq,
  output logic [FREQ_W-1:0] offset_freq,
  output logic              center_zero,
  output logic              serial_zero
);
  fcr_sel_e          sel;
  logic [IDX_W-1:0]  byte_idx;
  logic [FREQ_W-1:0] master_center;
  logic [FREQ_W-1:0] master_offset;
  logic [CTRL_W-1:0] master_ctrl;
  logic [CTRL_W-1:0] slave_ctrl;
  logic              rst_sync_n;
  logic              upd_sync_n;
  logic              load;

  // oscillator-domain reset: asserts at once, releases after SYNC_STAGES edges
  fcr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (dds_clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  fcr_addr_decode #(.ADDR_W(ADDR_W), .FREQ_BYTES(FREQ_BYTES)) u_decode (
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .sel      (sel),
    .byte_idx (byte_idx)
  );

  fcr_master_bank #(.BYTE_W(BYTE_W), .FREQ_BYTES(FREQ_BYTES)) u_master (
    .wr_clk        (wr_clk),
    .rst_n         (rst_n),
    .sel           (sel),
    .byte_idx      (byte_idx),
    .wr_data       (wr_data),
    .master_center (master_center),
    .master_offset (master_offset),
    .master_ctrl   (master_ctrl)
  );

  // update request crosses into the oscillator domain; idles inactive (high)
  fcr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_upd_sync (
    .clk   (dds_clk),
    .rst_n (rst_sync_n),
    .d     (update_n),
    .q     (upd_sync_n)
  );

  assign load = ~upd_sync_n;

  fcr_slave_bank #(.FREQ_W(FREQ_W)) u_slave (
    .dds_clk       (dds_clk),
    .rst_n         (rst_sync_n),
    .load          (load),
    .master_center (master_center),
    .master_offset (master_offset),
    .master_ctrl   (master_ctrl),
    .slave_center  (center_freq),
    .slave_offset  (offset_freq),
    .slave_ctrl    (slave_ctrl)
  );

  assign center_zero = slave_ctrl[CTRL_CZ_BIT];
  assign serial_zero = slave_ctrl[CTRL_SZ_BIT];
endmodule

// File: rtl/freq_ctl_regs_chk.sv
module freq_ctl_regs_chk #(
  parameter int BYTE_W     = 8,
  parameter int FREQ_BYTES = 6,
  parameter int ADDR_W     = 4,
  parameter int CTRL_W     = 2,
  localparam int FREQ_W    = BYTE_W * FREQ_BYTES
) (
  input logic              dds_clk,
  input logic              wr_clk,
  input logic              rst_n,
  input logic              rst_sync_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              update_n,
  input logic [FREQ_W-1:0] center_freq,
  input logic [FREQ_W-1:0] offset_freq,
  input logic              center_zero,
  input logic              serial_zero,
  input logic [FREQ_W-1:0] master_center,
  input logic [FREQ_W-1:0] master_offset,
  input logic [CTRL_W-1:0] master_ctrl
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(2 * FREQ_BYTES);

  assert_reset_clear_R1 : assert property (@(posedge dds_clk)
    !rst_sync_n |-> (center_freq == '0 && offset_freq == '0 && !center_zero && !serial_zero));

  assert_no_write_when_disabled_R5 : assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_en |=> ($stable(master_center) && $stable(master_offset) && $stable(master_ctrl)));

  assert_unused_addr_ignored_R6 : assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_en && wr_addr > LAST_ADDR) |=> ($stable(master_center) && $stable(master_offset) && $stable(master_ctrl)));

  assert_hold_while_idle_R7 : assert property (@(posedge dds_clk) disable iff (!rst_sync_n)
    ($past(update_n, 3) && $past(update_n, 2)) |->
      ($stable(center_freq) && $stable(offset_freq) && $stable(center_zero) && $stable(serial_zero)));

  assert_no_early_load_R8 : assert property (@(posedge dds_clk) disable iff (!rst_sync_n)
    ($past(update_n, 2) && $fell(update_n)) |=> ($stable(center_freq) && $stable(offset_freq)));
endmodule

bind freq_ctl_regs freq_ctl_regs_chk #(
  .BYTE_W     (BYTE_W),
  .FREQ_BYTES (FREQ_BYTES),
  .ADDR_W     (ADDR_W),
  .CTRL_W     (fcr_pkg::CTRL_W)
) u_chk (
  .dds_clk       (dds_clk),
  .wr_clk        (wr_clk),
  .rst_n         (rst_n),
  .rst_sync_n    (rst_sync_n),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .update_n      (update_n),
  .center_freq   (center_freq),
  .offset_freq   (offset_freq),
  .center_zero   (center_zero),
  .serial_zero   (serial_zero),
  .master_center (master_center),
  .master_offset (master_offset),
  .master_ctrl   (master_ctrl)
);

// File: tb/freq_ctl_regs_bench.sv
`timescale 1ns/1ps
module freq_ctl_regs_bench;
  logic        rst_n;
  logic        dds_clk;
  logic        wr_clk;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [7:0]  wr_data;
  logic        update_n;
  logic [47:0] center_freq;
  logic [47:0] offset_freq;
  logic        center_zero;
  logic        serial_zero;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // bench model of the master bank and of the expected slave outputs
  logic [7:0]  m_ctr [6];
  logic [7:0]  m_off [6];
  logic [1:0]  m_ctl;
  logic [47:0] e_ctr;
  logic [47:0] e_off;
  logic [1:0]  e_ctl;

  freq_ctl_regs u_freq_ctl_regs (
    .rst_n       (rst_n),
    .dds_clk     (dds_clk),
    .wr_clk      (wr_clk),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .update_n    (update_n),
    .center_freq (center_freq),
    .offset_freq (offset_freq),
    .center_zero (center_zero),
    .serial_zero (serial_zero)
  );

  initial dds_clk = 1'b0;
  always #2 dds_clk = ~dds_clk;

  function automatic logic [47:0] pack6(input logic [7:0] b0, b1, b2, b3, b4, b5);
    return {b5, b4, b3, b2, b1, b0};
  endfunction

  function automatic logic [47:0] model_ctr();
    return pack6(m_ctr[0], m_ctr[1], m_ctr[2], m_ctr[3], m_ctr[4], m_ctr[5]);
  endfunction

  function automatic logic [47:0] model_off();
    return pack6(m_off[0], m_off[1], m_off[2], m_off[3], m_off[4], m_off[5]);
  endfunction

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " center"}, center_freq, e_ctr);
    check({tag, " offset"}, offset_freq, e_off);
    check({tag, " flags"}, {46'd0, serial_zero, center_zero}, {46'd0, e_ctl});
  endtask

  // one byte write on wr_clk; period 8 ns, twice the oscillator period
  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic en);
    wr_addr = a;
    wr_data = d;
    wr_en   = en;
    #2 wr_clk = 1'b1;
    if (en) begin
      if (a < 4'd6)        m_ctr[a]         = d;
      else if (a < 4'd12)  m_off[a - 4'd6]  = d;
      else if (a == 4'd12) m_ctl            = d[1:0];
    end
    #4 wr_clk = 1'b0;
    #2 wr_en = 1'b0;
  endtask

  // pulse update and verify the three-edge latency (R8)
  task automatic do_update(input string tag);
    @(negedge dds_clk);
    update_n = 1'b0;
    repeat (2) @(negedge dds_clk);
    check_all({tag, " R8 before third edge"});
    @(negedge dds_clk);
    e_ctr = model_ctr();
    e_off = model_off();
    e_ctl = m_ctl;
    check_all({tag, " R8 after third edge"});
    update_n = 1'b1;
    repeat (4) @(negedge dds_clk);
    check_all({tag, " R11 held after release"});
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20417));
    rst_n = 1'b0; wr_clk = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; update_n = 1'b1;
    for (int i = 0; i < 6; i++) begin m_ctr[i] = '0; m_off[i] = '0; end
    m_ctl = '0; e_ctr = '0; e_off = '0; e_ctl = '0;
    repeat (5) @(negedge dds_clk);
    check_all("R1 during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge dds_clk);
    do_update("R1 update after reset");

    // R2 R3 R4: full sequential load with distinct bytes
    for (int a = 0; a < 6; a++) wr(4'(a), 8'(8'h11 * (a + 1)), 1'b1);
    for (int a = 6; a < 12; a++) wr(4'(a), 8'(8'hA0 + a), 1'b1);
    wr(4'd12, 8'hFD, 1'b1);
    repeat (6) @(negedge dds_clk);
    check_all("R7 no transfer without update");
    do_update("R2 R3 R4 full load");
    check("R2 center lanes", center_freq, 48'h6655_4433_2211);
    check("R3 offset lanes", offset_freq, 48'hABAA_A9A8_A7A6);
    check("R4 flags", {46'd0, serial_zero, center_zero}, 48'd1);

    // R5 and R6: disabled and out-of-map writes
    wr(4'd0, 8'hFF, 1'b0);
    wr(4'd13, 8'h5A, 1'b1);
    wr(4'd14, 8'hC3, 1'b1);
    wr(4'd15, 8'h3C, 1'b1);
    do_update("R5 R6 ignored writes");
    check("R5 R6 center kept", center_freq, 48'h6655_4433_2211);

    // R10: partial write, upper bytes untouched
    for (int a = 0; a < 4; a++) wr(4'(a), 8'(8'hE0 + a), 1'b1);
    do_update("R10 partial");
    check("R10 partial center", center_freq, 48'h6655_E3E2_E1E0);

    // R9: tracking while update held low
    @(negedge dds_clk);
    update_n = 1'b0;
    repeat (4) @(negedge dds_clk);
    wr(4'd7, 8'h5C, 1'b1);
    wr(4'd12, 8'h02, 1'b1);
    repeat (3) @(negedge dds_clk);
    e_ctr = model_ctr(); e_off = model_off(); e_ctl = m_ctl;
    check_all("R9 tracking");
    update_n = 1'b1;
    repeat (4) @(negedge dds_clk);
    wr(4'd7, 8'h99, 1'b1);
    repeat (4) @(negedge dds_clk);
    check_all("R11 frozen after release");

    // seeded random bursts
    for (int r = 0; r < 60; r++) begin
      int nw;
      nw = 1 + int'($urandom % 8);
      for (int k = 0; k < nw; k++)
        wr(4'($urandom % 16), 8'($urandom), ($urandom % 4) != 0);
      repeat (3) @(negedge dds_clk);
      check_all("R7 random hold");
      if ($urandom % 3 != 0) do_update("R8 R10 random");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule